// File: doc/BRIEF.md
# Keypad Code-Lock Alarm Controller

A synchronous controller for a door and window intrusion alarm. A user works it with four pushbutton keys. The controller holds one of two modes, Armed or Disarmed, and shows each mode on its own LED. In Armed mode, pressing four keys in the right order disarms the system. In Disarmed mode, pressing two keys in the right order arms it again. Three progress LEDs fill up as correct keys are accepted.

While Armed, a wrong key or an open door or window sensor sets a latched alarm output. Only a complete disarm sequence clears that alarm. The key lines and the sensor line are asynchronous to the clock. Each passes through a two-flop synchronizer, and the keys also go through an edge detector, so that one press counts as exactly one step. The outputs are decoded from registered state only (Moore style).

Top module: `keylock_alarm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the controller Armed: `armed_led`=1, `disarmed_led`=0, `prog_led`=000 and `alarm_out`=0.
- R2: Exactly one of `armed_led` and `disarmed_led` is high at all times.
- R3: Bit i of `keys_in` is key i. A press is a 0-to-1 change of the OR of the synchronized keys. Its effect shows on the outputs after the third rising clock edge that follows the change on the pins. Holding a key down counts as one press.
- R4: In Armed mode, keys 2, 0, 3, 1 pressed in that order (the parameter defaults) switch the controller to Disarmed. This also clears `prog_led` and `alarm_out`.
- R5: In Disarmed mode, keys 1, 2 pressed in that order (the parameter defaults) switch the controller to Armed with `prog_led`=000.
- R6: In Disarmed mode, a wrong key sends progress back to the first step (`prog_led`=000). The controller stays Disarmed and `alarm_out` stays 0.
- R7: In Armed mode, a wrong key sends progress back to the first step (`prog_led`=000), keeps the controller Armed and sets `alarm_out`. This also applies after one or more correct keys.
- R8: A press in which more than one key is asserted counts as a wrong key.
- R9: A high `sensor_in` while Armed sets `alarm_out`, through a two-flop synchronizer (visible after the third rising edge). `sensor_in` has no effect while Disarmed.
- R10: Once set, `alarm_out` stays high while Armed, even after `sensor_in` returns to 0. It is cleared only by completing the disarm sequence.
- R11: `prog_led` shows the number n of accepted keys as a thermometer code, with the low n bits lit (n = 0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| keys_in | input | 4 | Pushbutton keys, bit i = key i, asynchronous |
| sensor_in | input | 1 | 1 = door or window open, asynchronous |
| prog_led | output | 3 | Progress LEDs, thermometer code |
| armed_led | output | 1 | High in Armed mode |
| disarmed_led | output | 1 | High in Disarmed mode |
| alarm_out | output | 1 | Buzzer drive, latched |

## Verification
The bench goes after several corner cases:
- A key held for many cycles. A design without an edge detector would step the sequence once per clock.
- A chord of two keys. A design that decodes only the lowest set bit would accept it.
- A wrong key after correct ones. A design that does not restart would keep its partial progress.
- `sensor_in` dropping back to 0. A design without a latch would silence the buzzer.
- The sensor while Disarmed, which must be ignored.
- The exact edge on which a press takes effect, to catch a missing or an extra synchronizer stage.

// File: rtl/keylock_alarm.sv
module keylock_alarm #(
  parameter int NKEYS  = 4,
  parameter int DIS_K0 = 2,
  parameter int DIS_K1 = 0,
  parameter int DIS_K2 = 3,
  parameter int DIS_K3 = 1,
  parameter int ARM_K0 = 1,
  parameter int ARM_K1 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NKEYS-1:0] keys_in,
  input  logic             sensor_in,
  output logic [2:0]       prog_led,
  output logic             armed_led,
  output logic             disarmed_led,
  output logic             alarm_out
);
  localparam int KW = $clog2(NKEYS);

  logic [NKEYS-1:0] key_s1, key_s2, key_s3;
  logic             sen_s1, sen_s2;
  logic             armed, alarm;
  logic [1:0]       step;
  logic [KW-1:0]    tgt;

  always_comb begin
    if (armed)
      case (step)
        2'd0:    tgt = KW'(DIS_K0);
        2'd1:    tgt = KW'(DIS_K1);
        2'd2:    tgt = KW'(DIS_K2);
        default: tgt = KW'(DIS_K3);
      endcase
    else
      tgt = step[0] ? KW'(ARM_K1) : KW'(ARM_K0);
  end

  wire press = (|key_s2) && !(|key_s3);
  wire hit   = press && (key_s2 == (NKEYS'(1) << tgt));
  wire miss  = press && !hit;
  wire last  = armed ? (step == 2'd3) : (step == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_s1 <= '0;
      key_s2 <= '0;
      key_s3 <= '0;
      sen_s1 <= 1'b0;
      sen_s2 <= 1'b0;
      armed  <= 1'b1;
      step   <= 2'd0;
      alarm  <= 1'b0;
    end else begin
      key_s1 <= keys_in;
      key_s2 <= key_s1;
      key_s3 <= key_s2;
      sen_s1 <= sensor_in;
      sen_s2 <= sen_s1;
      if (hit && last) begin
        armed <= ~armed;
        step  <= 2'd0;
      end else if (hit) begin
        step <= step + 2'd1;
      end else if (miss) begin
        step <= 2'd0;
      end
      if (armed && hit && last)
        alarm <= 1'b0;
      else if (armed && (miss || sen_s2))
        alarm <= 1'b1;
    end
  end

  assign prog_led     = {step >= 2'd3, step >= 2'd2, step >= 2'd1};
  assign armed_led    = armed;
  assign disarmed_led = ~armed;
  assign alarm_out    = alarm;
endmodule

module keylock_alarm_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] prog_led,
  input logic       armed_led,
  input logic       disarmed_led,
  input logic       alarm_out
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (armed_led && !alarm_out && prog_led == 3'b000));

  // R2
  one_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({armed_led, disarmed_led}));

  // R6
  quiet_disarmed_chk: assert property (@(posedge clk) disable iff (rst)
    disarmed_led |-> (!alarm_out && prog_led[2:1] == 2'b00));

  // R10
  alarm_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_out && armed_led) |=> (alarm_out || disarmed_led));

  // R11
  thermo_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_led == 3'b000 || prog_led == 3'b001 ||
     prog_led == 3'b011 || prog_led == 3'b111));

  // R5
  arm_clears_prog_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_led) |-> (prog_led == 3'b000));
endmodule

bind keylock_alarm keylock_alarm_chk u_chk (
  .clk(clk), .rst(rst), .prog_led(prog_led), .armed_led(armed_led),
  .disarmed_led(disarmed_led), .alarm_out(alarm_out)
);

// File: tb/keylock_alarm_test.sv
module keylock_alarm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] keys_in = 4'b0;
  logic       sensor_in = 1'b0;
  logic [2:0] prog_led;
  logic       armed_led, disarmed_led, alarm_out;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  keylock_alarm uut (
    .clk(clk), .rst(rst), .keys_in(keys_in), .sensor_in(sensor_in),
    .prog_led(prog_led), .armed_led(armed_led),
    .disarmed_led(disarmed_led), .alarm_out(alarm_out)
  );

  // {key[9:6], sensor[5], armed[4], prog[3:1], alarm[0]}; key 0 = no press
  localparam int NV = 26;
  localparam logic [9:0] VEC [NV] = '{
    {4'b0100,1'b0,1'b1,3'b001,1'b0},  // R4 R11
    {4'b0001,1'b0,1'b1,3'b011,1'b0},
    {4'b1000,1'b0,1'b1,3'b111,1'b0},
    {4'b0010,1'b0,1'b0,3'b000,1'b0},  // R4 disarmed
    {4'b0010,1'b0,1'b0,3'b001,1'b0},  // R5
    {4'b1000,1'b0,1'b0,3'b000,1'b0},  // R6 wrong
    {4'b0010,1'b0,1'b0,3'b001,1'b0},
    {4'b0100,1'b0,1'b1,3'b000,1'b0},  // R5 armed
    {4'b0100,1'b0,1'b1,3'b001,1'b0},
    {4'b0001,1'b0,1'b1,3'b011,1'b0},
    {4'b0010,1'b0,1'b1,3'b000,1'b1},  // R7 wrong after two correct
    {4'b0100,1'b0,1'b1,3'b001,1'b1},  // R10
    {4'b0001,1'b0,1'b1,3'b011,1'b1},
    {4'b1000,1'b0,1'b1,3'b111,1'b1},
    {4'b0010,1'b0,1'b0,3'b000,1'b0},  // R4 clears alarm
    {4'b0000,1'b1,1'b0,3'b000,1'b0},  // R9 sensor ignored disarmed
    {4'b0010,1'b1,1'b0,3'b001,1'b0},
    {4'b0100,1'b0,1'b1,3'b000,1'b0},
    {4'b0000,1'b1,1'b1,3'b000,1'b1},  // R9 sensor armed
    {4'b0000,1'b0,1'b1,3'b000,1'b1},  // R10 latched
    {4'b0100,1'b0,1'b1,3'b001,1'b1},
    {4'b0101,1'b0,1'b1,3'b000,1'b1},  // R8 chord
    {4'b0100,1'b0,1'b1,3'b001,1'b1},
    {4'b0001,1'b0,1'b1,3'b011,1'b1},
    {4'b1000,1'b0,1'b1,3'b111,1'b1},
    {4'b0010,1'b0,1'b0,3'b000,1'b0}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] k, input int hold);
    keys_in = k;
    wait_n(hold);
    keys_in = 4'b0;
    wait_n(5);
  endtask

  task automatic check(input string req, input logic arm, input logic [2:0] pr,
                       input logic al);
    checks++;
    if (armed_led !== arm || disarmed_led !== ~arm || prog_led !== pr || alarm_out !== al) begin
      fails++;
      $display("FAIL %s: got armed=%b disarmed=%b prog=%b alarm=%b, expected armed=%b disarmed=%b prog=%b alarm=%b",
               req, armed_led, disarmed_led, prog_led, alarm_out, arm, ~arm, pr, al);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    keys_in = 4'b0;
    sensor_in = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset", 1'b1, 3'b000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      sensor_in = VEC[i][5];
      wait_n(5);
      if (VEC[i][9:6] != 4'b0) press(VEC[i][9:6], 5);
      check($sformatf("R2 vector %0d", i), VEC[i][4], VEC[i][3:1], VEC[i][0]);
    end
    sensor_in = 1'b0;

    // R3 held key counts once
    do_reset();
    press(4'b0100, 40);
    check("R3 held key", 1'b1, 3'b001, 1'b0);

    // R3 latency: third rising edge after the pin change
    do_reset();
    keys_in = 4'b0100;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 no effect after two edges", 1'b1, 3'b000, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R3 effect after third edge", 1'b1, 3'b001, 1'b0);
    keys_in = 4'b0;
    wait_n(5);

    // R9 sensor latency and R1 reset mid-sequence
    sensor_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 sensor before third edge", 1'b1, 3'b001, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R9 sensor after third edge", 1'b1, 3'b001, 1'b1);
    do_reset();
    check("R1 reset clears alarm and progress", 1'b1, 3'b000, 1'b0);

    // R7 wrong first key
    press(4'b1000, 5);
    check("R7 wrong first key", 1'b1, 3'b000, 1'b1);

    // R8 chord in disarmed mode counts as wrong
    press(4'b0100, 5); press(4'b0001, 5); press(4'b1000, 5); press(4'b0010, 5);
    press(4'b0010, 5);
    press(4'b0110, 5);
    check("R8 chord disarmed", 1'b0, 3'b000, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule